// File: doc/BRIEF.md
# Epoch-Based Two-Way Partition Tuner

This controller decides how many of the 16 allocation units of a shared cache belong to core 0 and how many to core 1. It adjusts that split at run time by hill climbing. A round lasts up to three epochs. The split that currently holds runs for one epoch, then the neighbour with one unit fewer for core 0, then the neighbour with one unit more. The candidate with the fewest misses becomes the split for the next round. Epoch boundaries come from an external pulse. Misses arrive as one strobe bit per core per cycle. The tuner only publishes the allocation: the cache applies it.

A start pulse begins tuning from the held split. A stop pulse ends tuning and puts the held split back on the outputs, even in the middle of a trial epoch. With the convergence-exit enable set, the tuner stops by itself when a round keeps the current split. All pins are plain control and status pins. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `split_tuner`

## Requirements
- R1: After reset, core 0 and core 1 each hold 8 units, the phase output reads 0 (current split) and `active` is low.
- R2: The two allocations always add up to 16, and neither falls below 1.
- R3: While `active` is low, epoch pulses and miss strobes change nothing. A start pulse raises `active` one cycle later with phase 0 and the held split unchanged. A start pulse while `active` is high is ignored.
- R4: While tuning, the phase output and the allocations change only on an epoch pulse. Phase codes are 0 for the current split, 1 for the trial with core 0 at held−1, and 2 for the trial with core 0 at held+1. They follow the order 0, 1, 2, 0.
- R5: A trial that would leave either core with fewer than 1 unit is skipped. With held split 1, phase 0 goes straight to phase 2. With held split 15, the result is decided at the end of phase 1.
- R6: At the end of a round, the candidate with the lowest miss count becomes the held split. On a tie, the current split wins first, then the held−1 split, then the held+1 split.
- R7: An epoch's miss count is the number of asserted `miss_strobe` bits over all of that epoch's cycles, including the cycle of the epoch pulse. It restarts from zero in every epoch and saturates at 65535.
- R8: A stop pulse drops `active` one cycle later, sets the phase to 0 and shows the held split on the outputs. Stop takes priority over start and over an epoch pulse in the same cycle.
- R9: When `conv_exit_en` is high and a round keeps the current split, `active` drops together with the decision. When the round moves the split, `active` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse: begin tuning from the held split |
| stop | input | 1 | Pulse: end tuning and hold the last chosen split |
| conv_exit_en | input | 1 | Stop by itself when a round keeps the split |
| epoch_tick | input | 1 | Pulse marking the last cycle of an epoch |
| miss_strobe | input | 2 | One miss event per bit per cycle, bit i for core i |
| alloc_core0 | output | 5 | Units given to core 0 |
| alloc_core1 | output | 5 | Units given to core 1 |
| phase | output | 2 | 0 current split, 1 trial held−1, 2 trial held+1 |
| active | output | 1 | High while tuning |

## Verification
The assertions check, on every cycle, the properties that involve no stored counts. These are the sum and the floor of the split, the legal phase codes, the one-unit steps into each trial, the skip at the low edge, that nothing moves between epoch pulses, and what start and stop do. The choice of winner, the tie order, saturation, clearing the counter at each epoch and convergence exit all depend on miss counts collected over earlier epochs. Only the bench shows these: it sweeps every tie and ordering pattern of three counts, walks the split to both ends and runs an epoch long enough to saturate the counter.

// File: rtl/split_tuner_pkg.sv
package split_tuner_pkg;

  // Phase of the search round; the codes appear on the phase output.
  typedef enum logic [1:0] {
    PH_RUN_CUR = 2'd0,
    PH_TRY_DEC = 2'd1,
    PH_TRY_INC = 2'd2
  } phase_e;

  // Winner of a round.
  typedef enum logic [1:0] {
    PICK_CUR = 2'd0,
    PICK_DEC = 2'd1,
    PICK_INC = 2'd2
  } pick_e;

endpackage

// File: rtl/split_tuner_miss_accum.sv
module split_tuner_miss_accum #(
  parameter int NSRC  = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             enable,
  input  logic [NSRC-1:0]  strobe,
  output logic [CNT_W-1:0] total
);
  localparam int IW = $clog2(NSRC + 1);
  localparam logic [CNT_W-1:0] SAT = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [NSRC-1:0]  gated;
  logic [IW-1:0]    hits;
  logic [CNT_W:0]   sum;

  assign gated = enable ? strobe : '0;

  // Count the set bits among this cycle's strobes.
  always_comb begin
    hits = '0;
    for (int i = 0; i < NSRC; i++) begin
      hits = hits + IW'(gated[i]);
    end
  end

  // The total includes the present cycle, so an epoch pulse sees its own strobes.
  assign sum   = {1'b0, cnt_q} + (CNT_W + 1)'(hits);
  assign total = sum[CNT_W] ? SAT : sum[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (enable) begin
      cnt_q <= total;
    end
  end

endmodule

// File: rtl/split_tuner_select.sv
module split_tuner_select
  import split_tuner_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_cur,
  input  logic [CNT_W-1:0] cnt_dec,
  input  logic [CNT_W-1:0] cnt_inc,
  input  logic             dec_ok,
  input  logic             inc_ok,
  output pick_e            pick
);
  logic [CNT_W-1:0] best;

  // Only a strictly lower count replaces the leader, so a tie goes to the
  // current split first and to the lower neighbour second.
  always_comb begin
    best = cnt_cur;
    pick = PICK_CUR;
    if (dec_ok && (cnt_dec < best)) begin
      best = cnt_dec;
      pick = PICK_DEC;
    end
    if (inc_ok && (cnt_inc < best)) begin
      pick = PICK_INC;
    end
  end

endmodule

// File: rtl/split_tuner_seq.sv
module split_tuner_seq
  import split_tuner_pkg::*;
#(
  parameter int TOTAL_UNITS = 16,
  parameter int MIN_UNITS   = 1,
  parameter int STEP_UNITS  = 1,
  parameter int AW          = 5,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             conv_exit_en,
  input  logic             epoch_end,
  input  logic [CNT_W-1:0] live_cnt,
  input  pick_e            pick,
  output logic             active,
  output phase_e           phase,
  output logic [AW-1:0]    base,
  output logic [CNT_W-1:0] cnt_cur_q,
  output logic [CNT_W-1:0] cnt_dec_q,
  output logic             dec_ok,
  output logic             inc_ok,
  output logic [AW-1:0]    trial_alloc
);
  localparam logic [AW-1:0] INIT_SPLIT = AW'(TOTAL_UNITS / 2);
  localparam logic [AW-1:0] STEP       = AW'(STEP_UNITS);
  localparam logic [AW-1:0] LOW_LIMIT  = AW'(MIN_UNITS + STEP_UNITS);
  localparam logic [AW-1:0] HIGH_LIMIT = AW'(TOTAL_UNITS - MIN_UNITS - STEP_UNITS);

  phase_e        phase_n;
  logic          decide;
  logic [AW-1:0] base_n;

  // Which neighbours keep both cores at or above the floor.
  assign dec_ok = (base >= LOW_LIMIT);
  assign inc_ok = (base <= HIGH_LIMIT);

  always_comb begin
    case (phase)
      PH_TRY_DEC: trial_alloc = base - STEP;
      PH_TRY_INC: trial_alloc = base + STEP;
      default:    trial_alloc = base;
    endcase
  end

  always_comb begin
    case (pick)
      PICK_DEC: base_n = base - STEP;
      PICK_INC: base_n = base + STEP;
      default:  base_n = base;
    endcase
  end

  // Next phase at an epoch pulse, skipping trials that are not allowed.
  always_comb begin
    decide  = 1'b0;
    phase_n = phase;
    case (phase)
      PH_RUN_CUR: begin
        if (dec_ok)      phase_n = PH_TRY_DEC;
        else if (inc_ok) phase_n = PH_TRY_INC;
        else             decide  = 1'b1;
      end
      PH_TRY_DEC: begin
        if (inc_ok) phase_n = PH_TRY_INC;
        else        decide  = 1'b1;
      end
      default: decide = 1'b1;
    endcase
    if (decide) phase_n = PH_RUN_CUR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      phase     <= PH_RUN_CUR;
      base      <= INIT_SPLIT;
      cnt_cur_q <= '0;
      cnt_dec_q <= '0;
    end else if (stop) begin
      active <= 1'b0;
      phase  <= PH_RUN_CUR;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        phase  <= PH_RUN_CUR;
      end
    end else if (epoch_end) begin
      phase <= phase_n;
      if (phase == PH_RUN_CUR) cnt_cur_q <= live_cnt;
      if (phase == PH_TRY_DEC) cnt_dec_q <= live_cnt;
      if (decide) begin
        base <= base_n;
        if (conv_exit_en && (pick == PICK_CUR)) active <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/split_tuner.sv
module split_tuner
  import split_tuner_pkg::*;
#(
  parameter int TOTAL_UNITS = 16,
  parameter int MIN_UNITS   = 1,
  parameter int STEP_UNITS  = 1,
  parameter int NCORE       = 2,
  parameter int CNT_W       = 16,
  localparam int AW         = $clog2(TOTAL_UNITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             conv_exit_en,
  input  logic             epoch_tick,
  input  logic [NCORE-1:0] miss_strobe,
  output logic [AW-1:0]    alloc_core0,
  output logic [AW-1:0]    alloc_core1,
  output logic [1:0]       phase,
  output logic             active
);
  localparam logic [AW-1:0] TOTAL = AW'(TOTAL_UNITS);

  logic             act_q;
  phase_e           ph_q;
  logic [AW-1:0]    base_q;
  logic [AW-1:0]    trial_alloc;
  logic [CNT_W-1:0] live_cnt;
  logic [CNT_W-1:0] cnt_cur_q;
  logic [CNT_W-1:0] cnt_dec_q;
  logic [CNT_W-1:0] sel_cur;
  logic [CNT_W-1:0] sel_dec;
  logic             dec_ok;
  logic             inc_ok;
  logic             clr;
  pick_e            pick;

  // The counter restarts after every epoch pulse and stays at zero while idle.
  assign clr = !act_q || epoch_tick || stop;

  split_tuner_miss_accum #(
    .NSRC  (NCORE),
    .CNT_W (CNT_W)
  ) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clr),
    .enable (act_q),
    .strobe (miss_strobe),
    .total  (live_cnt)
  );

  // The epoch now ending supplies its count live; earlier epochs come from registers.
  assign sel_cur = (ph_q == PH_RUN_CUR) ? live_cnt : cnt_cur_q;
  assign sel_dec = (ph_q == PH_TRY_DEC) ? live_cnt : cnt_dec_q;

  split_tuner_select #(
    .CNT_W (CNT_W)
  ) u_select (
    .cnt_cur (sel_cur),
    .cnt_dec (sel_dec),
    .cnt_inc (live_cnt),
    .dec_ok  (dec_ok),
    .inc_ok  (inc_ok),
    .pick    (pick)
  );

  split_tuner_seq #(
    .TOTAL_UNITS (TOTAL_UNITS),
    .MIN_UNITS   (MIN_UNITS),
    .STEP_UNITS  (STEP_UNITS),
    .AW          (AW),
    .CNT_W       (CNT_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .stop         (stop),
    .conv_exit_en (conv_exit_en),
    .epoch_end    (epoch_tick),
    .live_cnt     (live_cnt),
    .pick         (pick),
    .active       (act_q),
    .phase        (ph_q),
    .base         (base_q),
    .cnt_cur_q    (cnt_cur_q),
    .cnt_dec_q    (cnt_dec_q),
    .dec_ok       (dec_ok),
    .inc_ok       (inc_ok),
    .trial_alloc  (trial_alloc)
  );

  assign alloc_core0 = trial_alloc;
  assign alloc_core1 = TOTAL - trial_alloc;
  assign phase       = ph_q;
  assign active      = act_q;

endmodule

// File: rtl/split_tuner_chk.sv
module split_tuner_chk #(
  parameter int TOTAL_UNITS = 16,
  parameter int MIN_UNITS   = 1,
  parameter int STEP_UNITS  = 1,
  parameter int NCORE       = 2,
  parameter int AW          = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             stop,
  input logic             epoch_tick,
  input logic [NCORE-1:0] miss_strobe,
  input logic [AW-1:0]    alloc_core0,
  input logic [AW-1:0]    alloc_core1,
  input logic [1:0]       phase,
  input logic             active
);
  localparam logic [AW:0]   TOTAL = (AW + 1)'(TOTAL_UNITS);
  localparam logic [AW-1:0] FLOOR = AW'(MIN_UNITS);
  localparam logic [AW-1:0] STEP  = AW'(STEP_UNITS);
  localparam logic [AW-1:0] LO    = AW'(MIN_UNITS + STEP_UNITS);
  localparam logic [AW-1:0] HI    = AW'(TOTAL_UNITS - MIN_UNITS - STEP_UNITS);

  logic ep;
  assign ep = active && !stop && epoch_tick;

  AST_SPLIT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, alloc_core0} + {1'b0, alloc_core1}) == TOTAL); // R2
  AST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_core0 >= FLOOR) && (alloc_core1 >= FLOOR)); // R2
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3); // R4
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !stop && !epoch_tick) |=> ($stable(alloc_core0) && $stable(phase) && active)); // R4
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ep && phase == 2'd0 && alloc_core0 >= LO) |=> (phase == 2'd1 && alloc_core0 == $past(alloc_core0) - STEP)); // R4
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ep && phase == 2'd1 && (alloc_core0 + STEP) <= HI) |=> (phase == 2'd2 && alloc_core0 == $past(alloc_core0) + STEP + STEP)); // R4
  AST_SKIP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ep && phase == 2'd0 && alloc_core0 < LO && alloc_core0 <= HI) |=> (phase == 2'd2 && alloc_core0 == $past(alloc_core0) + STEP)); // R5
  AST_ROUND_END: assert property (@(posedge clk) disable iff (!rst_n)
    (ep && phase == 2'd2) |=> phase == 2'd0); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> (!active && $stable(alloc_core0) && phase == 2'd0)); // R3
  AST_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && start && !stop) |=> (active && phase == 2'd0 && $stable(alloc_core0))); // R3
  AST_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!active && phase == 2'd0)); // R8

endmodule

bind split_tuner split_tuner_chk #(
  .TOTAL_UNITS (TOTAL_UNITS),
  .MIN_UNITS   (MIN_UNITS),
  .STEP_UNITS  (STEP_UNITS),
  .NCORE       (NCORE),
  .AW          (AW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .stop        (stop),
  .epoch_tick  (epoch_tick),
  .miss_strobe (miss_strobe),
  .alloc_core0 (alloc_core0),
  .alloc_core1 (alloc_core1),
  .phase       (phase),
  .active      (active)
);

// File: tb/test_split_tuner.sv
`timescale 1ns/1ps
module test_split_tuner;
  localparam int TOTAL = 16;
  localparam int AW    = 5;
  localparam int SATV  = 65535;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          stop = 1'b0;
  logic          conv_exit_en = 1'b0;
  logic          epoch_tick = 1'b0;
  logic [1:0]    miss_strobe = 2'b00;
  logic [AW-1:0] alloc_core0;
  logic [AW-1:0] alloc_core1;
  logic [1:0]    phase;
  logic          active;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  // Expected state, kept from the requirements.
  int mb = 8;
  int mph = 0;
  int mact = 0;
  int mcur = 0;
  int mdec = 0;
  bit mconv = 1'b0;

  split_tuner i_split_tuner (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .stop         (stop),
    .conv_exit_en (conv_exit_en),
    .epoch_tick   (epoch_tick),
    .miss_strobe  (miss_strobe),
    .alloc_core0  (alloc_core0),
    .alloc_core1  (alloc_core1),
    .phase        (phase),
    .active       (active)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000 && !done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=%0d expected<150000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_alloc();
    if (mph == 1) return mb - 1;
    if (mph == 2) return mb + 1;
    return mb;
  endfunction

  task automatic chk_all(string req);
    chk(req, "alloc_core0", int'(alloc_core0), exp_alloc());
    chk(req, "alloc_core1", int'(alloc_core1), TOTAL - exp_alloc());
    chk(req, "phase", int'(phase), mph);
    chk(req, "active", int'(active), mact);
  endtask

  // R6, R5, R9: round bookkeeping for one epoch pulse with miss count cnt.
  task automatic model_tick(int cnt);
    int ph;
    bit dok;
    bit iok;
    bit decide;
    int best;
    int nb;
    if (mact == 0) return;
    ph = mph;
    dok = (mb >= 2);
    iok = (mb <= TOTAL - 2);
    decide = 1'b0;
    if (ph == 0) begin
      mcur = cnt;
      if (dok) mph = 1; else if (iok) mph = 2; else decide = 1'b1;
    end else if (ph == 1) begin
      mdec = cnt;
      if (iok) mph = 2; else decide = 1'b1;
    end else begin
      decide = 1'b1;
    end
    if (decide) begin
      best = mcur;
      nb = mb;
      if (dok && mdec < best) begin best = mdec; nb = mb - 1; end
      if (ph == 2 && cnt < best) nb = mb + 1;
      mph = 0;
      if (mconv && nb == mb) mact = 0;
      mb = nb;
    end
  endtask

  // R7: an epoch of len cycles with the strobe pattern m, pulse on the last cycle.
  task automatic do_epoch(int len, logic [1:0] m);
    int c;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      miss_strobe = m;
      epoch_tick = (i == len - 1);
    end
    @(negedge clk);
    miss_strobe = 2'b00;
    epoch_tick = 1'b0;
    c = len * (int'(m[0]) + int'(m[1]));
    if (c > SATV) c = SATV;
    model_tick(c);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mact == 0) begin mact = 1; mph = 0; end
  endtask

  task automatic pulse_stop();
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    mact = 0;
    mph = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1");

    // R3: idle epochs and misses leave everything untouched
    do_epoch(5, 2'b11);
    chk_all("R3");
    pulse_start();
    chk_all("R3");
    pulse_start();
    chk_all("R3");

    // R6: sweep every ordering and tie of three counts
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        for (int c = 0; c < 3; c++) begin
          logic [1:0] m;
          m = 2'((a + b + c) % 3 + 1);
          do begin
            int ln;
            ln = (mph == 0) ? 4 + 2 * a : (mph == 1) ? 4 + 2 * b : 4 + 2 * c;
            do_epoch(ln, m);
            chk_all("R6");
          end while (mph != 0 && mact != 0);
        end
      end
    end

    // R5: walk down to the floor, then all the way up
    for (int k = 0; k < 30; k++) begin
      do_epoch((mph == 1) ? 2 : 6, 2'b11);
      chk_all("R5");
    end
    chk("R5", "held split at low edge", mb, 1);
    for (int k = 0; k < 50; k++) begin
      do_epoch((mph == 2) ? 2 : 6, 2'b11);
      chk_all("R5");
    end
    chk("R5", "held split at high edge", mb, 15);

    // R8: stop in the middle of a trial restores the held split
    while (mph == 0) begin
      do_epoch(3, 2'b01);
      chk_all("R4");
    end
    pulse_stop();
    chk_all("R8");
    chk("R8", "alloc_core0 after stop", int'(alloc_core0), 15);

    // R7: saturation decides the round (a wrapped count would keep the split)
    pulse_start();
    chk_all("R3");
    do_epoch(40000, 2'b11);
    chk_all("R7");
    do_epoch(15000, 2'b01);
    chk_all("R7");
    chk("R7", "alloc_core0 after saturated round", int'(alloc_core0), 14);

    // R9: convergence exit
    pulse_stop();
    mconv = 1'b1;
    conv_exit_en = 1'b1;
    pulse_start();
    do_epoch(6, 2'b01); chk_all("R9");
    do_epoch(2, 2'b01); chk_all("R9");
    do_epoch(6, 2'b01); chk_all("R9");
    chk("R9", "active after moving round", int'(active), 1);
    do_epoch(2, 2'b01); chk_all("R9");
    do_epoch(6, 2'b01); chk_all("R9");
    do_epoch(6, 2'b01); chk_all("R9");
    chk("R9", "active after steady round", int'(active), 0);
    do_epoch(4, 2'b10);
    chk_all("R3");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule